// File: doc/BRIEF.md
# Cache Inquire Snoop Responder

This block answers coherency inquiries that external logic drives into a processor with split instruction and data caches. Once the system side has taken the address bus, it strobes an inquire address together with an invalidate qualifier. The block looks up the physical tags of both caches in the same cycle. One clock later it reports whether the address is cached clean (`snp_hit`) and whether it is cached dirty (`snp_hitm`). It then moves the matched lines to their new state. A dirty data line is downgraded or dropped only after its writeback request has been acknowledged.

Both tag arrays are direct-mapped. The data array keeps a four-state coherency code per line and the instruction array keeps a valid bit. A processor-side port beside the snoop port performs lookups, line fills and write hits. It never waits on a snoop. When both ports write the same line in one cycle, the snoop takes the line.

Top module: `snoop_responder`

## Requirements
- R1: After reset every line in both arrays is invalid: every lookup misses, and a snoop reports neither hit nor hit-modified.
- R2: A strobe while `bus_held` is low is ignored: both snoop outputs stay low and no line state changes.
- R3: `snp_hit` is high for exactly the one cycle after an accepted strobe whose address matches a data line in state S (1) or E (2), or a valid instruction line.
- R4: `snp_hitm` is high for exactly the one cycle after an accepted strobe whose address matches a data line in state M (3).
- R5: An accepted strobe whose tag differs from the stored tag at that index leaves both snoop outputs low.
- R6: With `inq_inval` low, a matched data line ends in state S (1). A matched instruction line stays valid.
- R7: With `inq_inval` high, a matched line in either array ends invalid.
- R8: On a hit-modified, `wb_req` rises together with `snp_hitm` and carries the line's index and tag. It holds until `wb_ack`. The line keeps state M until the acknowledge, and the state change is committed on that acknowledge.
- R9: A strobe that arrives while `wb_req` is high is ignored: both outputs stay low and no line changes.
- R10: When a snoop that hits a line and a processor fill or write to the same array and index occur in the same cycle, the snoop result is the state the line ends in.
- R11: A processor lookup issued in the same cycle as a snoop returns its response on the next cycle, with the line state from before the snoop.
- R12: Processor port encoding: `cpu_op` 0 = lookup, 1 = fill, 2 = write, 3 = no operation. `cpu_isel` 1 selects the instruction array. A fill installs the tag with state `cpu_fill_st` (for data) or valid (for instructions). A write that hits a data line sets it to M. A lookup answers one cycle later with `cpu_hit`, and with `cpu_state` holding the data state or 1 for a valid instruction line (0 on a miss).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_held | input | 1 | External logic holds the address bus |
| inq_strobe | input | 1 | Inquire address strobe |
| inq_addr | input | ADDR_W | Physical inquire address |
| inq_inval | input | 1 | Invalidate qualifier for the inquiry |
| snp_hit | output | 1 | Clean hit, one cycle after strobe |
| snp_hitm | output | 1 | Modified hit, one cycle after strobe |
| wb_req | output | 1 | Writeback request for a dirty line |
| wb_index | output | IDX_W | Index of the line to write back |
| wb_tag | output | ADDR_W-IDX_W-OFS_W | Tag of the line to write back |
| wb_ack | input | 1 | Writeback done; commits the state change |
| cpu_req | input | 1 | Processor-side request valid |
| cpu_op | input | 2 | Processor operation (R12) |
| cpu_isel | input | 1 | 1 selects the instruction array |
| cpu_addr | input | ADDR_W | Processor physical address |
| cpu_fill_st | input | 2 | State written by a data fill |
| cpu_hit | output | 1 | Lookup hit, one cycle after request |
| cpu_state | output | 2 | Looked-up line state |

## Verification
The bench builds the block with a 16-bit address, 3 index bits and 2 offset bits, which gives eight lines per array and an 11-bit tag. With so few lines, every index can be swept for the reset check. Two tags that alias at one index can be placed cheaply to show a tag miss. The writeback window can be held open for several cycles while new strobes and lookups arrive against it. Same-cycle collisions between the snoop and the processor port are forced on both arrays.

// File: rtl/sn_pkg.sv
package sn_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } coh_state_e;

   typedef enum logic [1:0] {
      OP_LOOK  = 2'd0,
      OP_FILL  = 2'd1,
      OP_WRITE = 2'd2,
      OP_NONE  = 2'd3
   } cpu_op_e;
endpackage

// File: rtl/sn_tag_bank.sv
// Direct-mapped tag store with two read ports and two write ports.
// The snoop write port (s_*) updates state only and outranks the
// processor write port (c_*) on the same line.
module sn_tag_bank #(
   parameter int IDX_W = 6,
   parameter int TAG_W = 21,
   parameter int ST_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   output logic [TAG_W-1:0] a_tag,
   output logic [ST_W-1:0]  a_st,
   input  logic [IDX_W-1:0] b_idx,
   output logic [TAG_W-1:0] b_tag,
   output logic [ST_W-1:0]  b_st,
   input  logic             s_we,
   input  logic [IDX_W-1:0] s_idx,
   input  logic [ST_W-1:0]  s_st,
   input  logic             c_we,
   input  logic [IDX_W-1:0] c_idx,
   input  logic [TAG_W-1:0] c_tag,
   input  logic [ST_W-1:0]  c_st
);
   localparam int LINES = 1 << IDX_W;

   logic [TAG_W-1:0] tag_w [LINES];
   logic [ST_W-1:0]  st_w  [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [TAG_W-1:0] tag_r;
      logic [ST_W-1:0]  st_r;
      logic             s_sel;
      logic             c_sel;

      assign s_sel = s_we && (s_idx == IDX_W'(g));
      assign c_sel = c_we && (c_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n)     st_r <= '0;
         else if (s_sel) st_r <= s_st;
         else if (c_sel) st_r <= c_st;
      end

      always_ff @(posedge clk) begin
         if (c_sel && !s_sel) tag_r <= c_tag;
      end

      assign tag_w[g] = tag_r;
      assign st_w[g]  = st_r;
   end

   assign a_tag = tag_w[a_idx];
   assign a_st  = st_w[a_idx];
   assign b_tag = tag_w[b_idx];
   assign b_st  = st_w[b_idx];
endmodule

// File: rtl/sn_snoop_ctl.sv
// Inquiry acceptance, hit reporting, writeback hold and state commit.
module sn_snoop_ctl
   import sn_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6,
   parameter int OFS_W  = 5,
   localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_held,
   input  logic              inq_strobe,
   input  logic [ADDR_W-1:0] inq_addr,
   input  logic              inq_inval,
   input  logic              wb_ack,
   output logic [IDX_W-1:0]  lk_idx,
   input  logic [TAG_W-1:0]  d_tag,
   input  logic [1:0]        d_st,
   input  logic [TAG_W-1:0]  i_tag,
   input  logic [0:0]        i_st,
   output logic              snp_hit,
   output logic              snp_hitm,
   output logic              wb_req,
   output logic [IDX_W-1:0]  wb_index,
   output logic [TAG_W-1:0]  wb_tag,
   output logic              ds_we,
   output logic [IDX_W-1:0]  ds_idx,
   output logic [1:0]        ds_st,
   output logic              is_we,
   output logic [IDX_W-1:0]  is_idx,
   output logic [0:0]        is_st
);
   logic [TAG_W-1:0] lk_tag;
   logic             accept, d_match, d_mod, i_match, commit;
   logic             pend_q, pinv_q;
   logic [IDX_W-1:0] wb_idx_q;
   logic [TAG_W-1:0] wb_tag_q;
   logic             unused_ofs;

   assign lk_idx     = inq_addr[OFS_W +: IDX_W];
   assign lk_tag     = inq_addr[ADDR_W-1 -: TAG_W];
   assign unused_ofs = ^inq_addr[OFS_W-1:0];

   assign accept  = inq_strobe && bus_held && !pend_q;
   assign d_match = (d_st != ST_I) && (d_tag == lk_tag);
   assign d_mod   = d_match && (d_st == ST_M);
   assign i_match = i_st[0] && (i_tag == lk_tag);
   assign commit  = pend_q && wb_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snp_hit  <= 1'b0;
         snp_hitm <= 1'b0;
      end else begin
         snp_hit  <= accept && ((d_match && !d_mod) || i_match);
         snp_hitm <= accept && d_mod;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         pinv_q   <= 1'b0;
         wb_idx_q <= '0;
         wb_tag_q <= '0;
      end else if (accept && d_mod) begin
         pend_q   <= 1'b1;
         pinv_q   <= inq_inval;
         wb_idx_q <= lk_idx;
         wb_tag_q <= lk_tag;
      end else if (commit) begin
         pend_q   <= 1'b0;
      end
   end

   assign wb_req   = pend_q;
   assign wb_index = wb_idx_q;
   assign wb_tag   = wb_tag_q;

   // Data array: a hit claims the line for this cycle; a dirty hit
   // rewrites M so a same-cycle processor update cannot slip in.
   always_comb begin
      ds_we  = commit || (accept && d_match);
      ds_idx = commit ? wb_idx_q : lk_idx;
      if (commit)         ds_st = pinv_q ? ST_I : ST_S;
      else if (d_mod)     ds_st = ST_M;
      else if (inq_inval) ds_st = ST_I;
      else                ds_st = ST_S;
   end

   assign is_we  = accept && i_match;
   assign is_idx = lk_idx;
   assign is_st  = ~inq_inval;
endmodule

// File: rtl/sn_cpu_port.sv
// Processor-side lookup, fill and write-hit port.
module sn_cpu_port
   import sn_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6,
   parameter int OFS_W  = 5,
   localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [1:0]        cpu_op,
   input  logic              cpu_isel,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [1:0]        cpu_fill_st,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [TAG_W-1:0]  d_tag,
   input  logic [1:0]        d_st,
   input  logic [TAG_W-1:0]  i_tag,
   input  logic [0:0]        i_st,
   output logic              cpu_hit,
   output logic [1:0]        cpu_state,
   output logic              dc_we,
   output logic [TAG_W-1:0]  dc_tag,
   output logic [1:0]        dc_st,
   output logic              ic_we,
   output logic [TAG_W-1:0]  ic_tag,
   output logic [0:0]        ic_st
);
   logic [TAG_W-1:0] c_tag;
   logic             hit_d, hit_i, is_look, is_fill, is_write;
   logic             unused_ofs;

   assign rd_idx     = cpu_addr[OFS_W +: IDX_W];
   assign c_tag      = cpu_addr[ADDR_W-1 -: TAG_W];
   assign unused_ofs = ^cpu_addr[OFS_W-1:0];

   assign hit_d    = (d_st != ST_I) && (d_tag == c_tag);
   assign hit_i    = i_st[0] && (i_tag == c_tag);
   assign is_look  = cpu_req && (cpu_op == OP_LOOK);
   assign is_fill  = cpu_req && (cpu_op == OP_FILL);
   assign is_write = cpu_req && (cpu_op == OP_WRITE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_hit   <= 1'b0;
         cpu_state <= ST_I;
      end else if (is_look) begin
         cpu_hit   <= cpu_isel ? hit_i : hit_d;
         if (cpu_isel) cpu_state <= hit_i ? ST_S : ST_I;
         else          cpu_state <= hit_d ? d_st : ST_I;
      end else begin
         cpu_hit   <= 1'b0;
         cpu_state <= ST_I;
      end
   end

   assign dc_we  = !cpu_isel && (is_fill || (is_write && hit_d));
   assign dc_tag = c_tag;
   assign dc_st  = is_fill ? cpu_fill_st : ST_M;
   assign ic_we  = cpu_isel && is_fill;
   assign ic_tag = c_tag;
   assign ic_st  = 1'b1;
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6,
   parameter int OFS_W  = 5,
   localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_held,
   input  logic              inq_strobe,
   input  logic [ADDR_W-1:0] inq_addr,
   input  logic              inq_inval,
   output logic              snp_hit,
   output logic              snp_hitm,
   output logic              wb_req,
   output logic [IDX_W-1:0]  wb_index,
   output logic [TAG_W-1:0]  wb_tag,
   input  logic              wb_ack,
   input  logic              cpu_req,
   input  logic [1:0]        cpu_op,
   input  logic              cpu_isel,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [1:0]        cpu_fill_st,
   output logic              cpu_hit,
   output logic [1:0]        cpu_state
);
   initial begin : p_param_chk
      assert (OFS_W >= 1) else $fatal(1, "OFS_W must be at least 1");
      assert (IDX_W >= 1 && IDX_W <= 10) else $fatal(1, "IDX_W out of range");
      assert (TAG_W >= 1) else $fatal(1, "address too narrow for index and offset");
   end

   logic [IDX_W-1:0] s_idx, c_idx;
   logic [TAG_W-1:0] d_tag_s, d_tag_c, i_tag_s, i_tag_c;
   logic [1:0]       d_st_s, d_st_c;
   logic [0:0]       i_st_s, i_st_c;
   logic             ds_we, is_we, dc_we, ic_we;
   logic [IDX_W-1:0] ds_idx, is_idx;
   logic [1:0]       ds_st, dc_st;
   logic [0:0]       is_st, ic_st;
   logic [TAG_W-1:0] dc_tag, ic_tag;

   sn_tag_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ST_W(2)) u_dtags (
      .clk(clk), .rst_n(rst_n),
      .a_idx(s_idx), .a_tag(d_tag_s), .a_st(d_st_s),
      .b_idx(c_idx), .b_tag(d_tag_c), .b_st(d_st_c),
      .s_we(ds_we), .s_idx(ds_idx), .s_st(ds_st),
      .c_we(dc_we), .c_idx(c_idx), .c_tag(dc_tag), .c_st(dc_st)
   );

   sn_tag_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ST_W(1)) u_itags (
      .clk(clk), .rst_n(rst_n),
      .a_idx(s_idx), .a_tag(i_tag_s), .a_st(i_st_s),
      .b_idx(c_idx), .b_tag(i_tag_c), .b_st(i_st_c),
      .s_we(is_we), .s_idx(is_idx), .s_st(is_st),
      .c_we(ic_we), .c_idx(c_idx), .c_tag(ic_tag), .c_st(ic_st)
   );

   sn_snoop_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_snoop (
      .clk(clk), .rst_n(rst_n), .bus_held(bus_held),
      .inq_strobe(inq_strobe), .inq_addr(inq_addr), .inq_inval(inq_inval),
      .wb_ack(wb_ack), .lk_idx(s_idx),
      .d_tag(d_tag_s), .d_st(d_st_s), .i_tag(i_tag_s), .i_st(i_st_s),
      .snp_hit(snp_hit), .snp_hitm(snp_hitm),
      .wb_req(wb_req), .wb_index(wb_index), .wb_tag(wb_tag),
      .ds_we(ds_we), .ds_idx(ds_idx), .ds_st(ds_st),
      .is_we(is_we), .is_idx(is_idx), .is_st(is_st)
   );

   sn_cpu_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_cpu (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
      .cpu_isel(cpu_isel), .cpu_addr(cpu_addr), .cpu_fill_st(cpu_fill_st),
      .rd_idx(c_idx),
      .d_tag(d_tag_c), .d_st(d_st_c), .i_tag(i_tag_c), .i_st(i_st_c),
      .cpu_hit(cpu_hit), .cpu_state(cpu_state),
      .dc_we(dc_we), .dc_tag(dc_tag), .dc_st(dc_st),
      .ic_we(ic_we), .ic_tag(ic_tag), .ic_st(ic_st)
   );
endmodule

// File: rtl/sn_snoop_checks.sv
module sn_snoop_checks #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6,
   parameter int OFS_W  = 5,
   localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_held,
   input logic             inq_strobe,
   input logic             snp_hit,
   input logic             snp_hitm,
   input logic             wb_req,
   input logic             wb_ack,
   input logic [IDX_W-1:0] wb_index,
   input logic [TAG_W-1:0] wb_tag,
   input logic             cpu_req,
   input logic [1:0]       cpu_op,
   input logic             cpu_hit
);
   a_r2_no_hold_no_result: assert property (@(posedge clk) disable iff (!rst_n)
      inq_strobe && !bus_held |=> !snp_hit && !snp_hitm);

   a_r3_hit_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      snp_hit |-> $past(inq_strobe && bus_held));

   a_r4_hitm_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      snp_hitm |-> $past(inq_strobe && bus_held));

   a_r8_wb_rises_with_hitm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wb_req) |-> snp_hitm);

   a_r8_wb_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && !wb_ack |=> wb_req && $stable(wb_index) && $stable(wb_tag));

   a_r8_wb_drops_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && wb_ack |=> !wb_req);

   a_r9_strobe_ignored_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && inq_strobe |=> !snp_hit && !snp_hitm);

   a_r12_cpu_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> $past(cpu_req && cpu_op == 2'd0));
endmodule

bind snoop_responder sn_snoop_checks #(
   .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)
) u_checks (
   .clk(clk), .rst_n(rst_n), .bus_held(bus_held), .inq_strobe(inq_strobe),
   .snp_hit(snp_hit), .snp_hitm(snp_hitm), .wb_req(wb_req), .wb_ack(wb_ack),
   .wb_index(wb_index), .wb_tag(wb_tag), .cpu_req(cpu_req), .cpu_op(cpu_op),
   .cpu_hit(cpu_hit)
);

// File: tb/test_snoop_responder.sv
`timescale 1ns/1ps
module test_snoop_responder;
   localparam int AW = 16;
   localparam int IW = 3;
   localparam int OW = 2;
   localparam int TW = AW - IW - OW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_held = 1'b0;
   logic          inq_strobe = 1'b0;
   logic [AW-1:0] inq_addr = '0;
   logic          inq_inval = 1'b0;
   logic          wb_ack = 1'b0;
   logic          cpu_req = 1'b0;
   logic [1:0]    cpu_op = 2'd3;
   logic          cpu_isel = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [1:0]    cpu_fill_st = 2'd0;
   logic          snp_hit, snp_hitm, wb_req, cpu_hit;
   logic [IW-1:0] wb_index;
   logic [TW-1:0] wb_tag;
   logic [1:0]    cpu_state;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   snoop_responder #(.ADDR_W(AW), .IDX_W(IW), .OFS_W(OW)) i_snoop_responder (
      .clk(clk), .rst_n(rst_n), .bus_held(bus_held), .inq_strobe(inq_strobe),
      .inq_addr(inq_addr), .inq_inval(inq_inval), .snp_hit(snp_hit),
      .snp_hitm(snp_hitm), .wb_req(wb_req), .wb_index(wb_index), .wb_tag(wb_tag),
      .wb_ack(wb_ack), .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_isel(cpu_isel),
      .cpu_addr(cpu_addr), .cpu_fill_st(cpu_fill_st), .cpu_hit(cpu_hit),
      .cpu_state(cpu_state)
   );

   function automatic logic [AW-1:0] mk(input int t, input int i);
      logic [TW-1:0] tt = TW'(t);
      logic [IW-1:0] ii = IW'(i);
      return {tt, ii, 2'b01};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic cpu_do(input int op, input bit isel, input logic [AW-1:0] a,
                         input int fst);
      @(negedge clk);
      cpu_req = 1'b1; cpu_op = 2'(op); cpu_isel = isel; cpu_addr = a;
      cpu_fill_st = 2'(fst);
      @(negedge clk);
      cpu_req = 1'b0; cpu_op = 2'd3;
   endtask

   task automatic look(input bit isel, input int t, input int i,
                       input bit eh, input int es, input string rq);
      cpu_do(0, isel, mk(t, i), 0);
      chk(cpu_hit == eh, rq, "lookup hit", int'(cpu_hit), int'(eh));
      chk(cpu_state == 2'(es), rq, "lookup state", int'(cpu_state), es);
   endtask

   task automatic snoop(input int t, input int i, input bit inv, input bit held,
                        output bit h, output bit hm);
      @(negedge clk);
      inq_strobe = 1'b1; inq_addr = mk(t, i); inq_inval = inv; bus_held = held;
      @(negedge clk);
      inq_strobe = 1'b0; inq_inval = 1'b0; bus_held = 1'b0;
      h = snp_hit; hm = snp_hitm;
   endtask

   task automatic ack_wb();
      @(negedge clk); wb_ack = 1'b1;
      @(negedge clk); wb_ack = 1'b0;
   endtask

   task automatic t_reset();
      bit h, hm;
      chk(wb_req == 1'b0, "R1", "wb_req after reset", int'(wb_req), 0);
      for (int i = 0; i < (1 << IW); i++) begin
         look(1'b0, 0, i, 1'b0, 0, "R1");
         look(1'b1, 0, i, 1'b0, 0, "R1");
      end
      snoop(0, 0, 1'b0, 1'b1, h, hm);
      chk(h == 0 && hm == 0, "R1", "snoop after reset", {h, hm}, 0);
   endtask

   task automatic t_data();
      bit h, hm;
      cpu_do(1, 1'b0, mk(12'h012, 1), 2);
      look(1'b0, 12'h012, 1, 1'b1, 2, "R12");
      snoop(12'h012, 1, 1'b1, 1'b0, h, hm);
      chk(h == 0 && hm == 0, "R2", "strobe without bus hold", {h, hm}, 0);
      look(1'b0, 12'h012, 1, 1'b1, 2, "R2");
      snoop(12'h012, 1, 1'b0, 1'b1, h, hm);
      chk(h == 1 && hm == 0, "R3", "clean data hit", {h, hm}, 2);
      @(negedge clk);
      chk(snp_hit == 0, "R3", "hit lasts one cycle", int'(snp_hit), 0);
      look(1'b0, 12'h012, 1, 1'b1, 1, "R6");
      snoop(12'h013, 1, 1'b1, 1'b1, h, hm);
      chk(h == 0 && hm == 0, "R5", "tag mismatch", {h, hm}, 0);
      snoop(12'h012, 1, 1'b1, 1'b1, h, hm);
      chk(h == 1 && hm == 0, "R3", "shared data hit", {h, hm}, 2);
      look(1'b0, 12'h012, 1, 1'b0, 0, "R7");
   endtask

   task automatic t_instr();
      bit h, hm;
      cpu_do(1, 1'b1, mk(12'h034, 2), 0);
      look(1'b1, 12'h034, 2, 1'b1, 1, "R12");
      snoop(12'h034, 2, 1'b0, 1'b1, h, hm);
      chk(h == 1 && hm == 0, "R3", "instruction hit", {h, hm}, 2);
      look(1'b1, 12'h034, 2, 1'b1, 1, "R6");
      snoop(12'h034, 2, 1'b1, 1'b1, h, hm);
      chk(h == 1 && hm == 0, "R3", "instruction hit inval", {h, hm}, 2);
      look(1'b1, 12'h034, 2, 1'b0, 0, "R7");
   endtask

   task automatic t_modified();
      bit h, hm;
      cpu_do(1, 1'b0, mk(12'h055, 3), 2);
      cpu_do(2, 1'b0, mk(12'h055, 3), 0);
      look(1'b0, 12'h055, 3, 1'b1, 3, "R12");
      cpu_do(1, 1'b0, mk(12'h066, 4), 2);
      snoop(12'h055, 3, 1'b0, 1'b1, h, hm);
      chk(h == 0 && hm == 1, "R4", "modified hit", {h, hm}, 1);
      chk(wb_req == 1, "R8", "wb_req with hitm", int'(wb_req), 1);
      chk(wb_index == 3'd3, "R8", "wb_index", int'(wb_index), 3);
      chk(wb_tag == 11'h055, "R8", "wb_tag", int'(wb_tag), 'h55);
      repeat (3) @(negedge clk);
      chk(wb_req == 1, "R8", "wb_req held", int'(wb_req), 1);
      look(1'b0, 12'h055, 3, 1'b1, 3, "R8");
      snoop(12'h066, 4, 1'b1, 1'b1, h, hm);
      chk(h == 0 && hm == 0, "R9", "strobe while pending", {h, hm}, 0);
      look(1'b0, 12'h066, 4, 1'b1, 2, "R9");
      ack_wb();
      chk(wb_req == 0, "R8", "wb_req after ack", int'(wb_req), 0);
      look(1'b0, 12'h055, 3, 1'b1, 1, "R6");
      cpu_do(2, 1'b0, mk(12'h055, 3), 0);
      snoop(12'h055, 3, 1'b1, 1'b1, h, hm);
      chk(hm == 1, "R4", "modified hit inval", int'(hm), 1);
      look(1'b0, 12'h055, 3, 1'b1, 3, "R8");
      ack_wb();
      look(1'b0, 12'h055, 3, 1'b0, 0, "R7");
   endtask

   task automatic t_collide();
      cpu_do(1, 1'b0, mk(12'h077, 5), 2);
      @(negedge clk);
      inq_strobe = 1'b1; inq_addr = mk(12'h077, 5); inq_inval = 1'b1; bus_held = 1'b1;
      cpu_req = 1'b1; cpu_op = 2'd2; cpu_isel = 1'b0; cpu_addr = mk(12'h077, 5);
      @(negedge clk);
      inq_strobe = 1'b0; inq_inval = 1'b0; bus_held = 1'b0; cpu_req = 1'b0; cpu_op = 2'd3;
      look(1'b0, 12'h077, 5, 1'b0, 0, "R10");
      cpu_do(1, 1'b1, mk(12'h010, 6), 0);
      @(negedge clk);
      inq_strobe = 1'b1; inq_addr = mk(12'h010, 6); inq_inval = 1'b1; bus_held = 1'b1;
      cpu_req = 1'b1; cpu_op = 2'd1; cpu_isel = 1'b1; cpu_addr = mk(12'h020, 6);
      @(negedge clk);
      inq_strobe = 1'b0; inq_inval = 1'b0; bus_held = 1'b0; cpu_req = 1'b0; cpu_op = 2'd3;
      look(1'b1, 12'h020, 6, 1'b0, 0, "R10");
      look(1'b1, 12'h010, 6, 1'b0, 0, "R10");
   endtask

   task automatic t_parallel();
      cpu_do(1, 1'b0, mk(12'h003, 7), 2);
      @(negedge clk);
      inq_strobe = 1'b1; inq_addr = mk(12'h003, 7); inq_inval = 1'b1; bus_held = 1'b1;
      cpu_req = 1'b1; cpu_op = 2'd0; cpu_isel = 1'b0; cpu_addr = mk(12'h003, 7);
      @(negedge clk);
      inq_strobe = 1'b0; inq_inval = 1'b0; bus_held = 1'b0; cpu_req = 1'b0; cpu_op = 2'd3;
      chk(cpu_hit == 1, "R11", "parallel lookup hit", int'(cpu_hit), 1);
      chk(cpu_state == 2'd2, "R11", "parallel lookup state", int'(cpu_state), 2);
      chk(snp_hit == 1, "R11", "parallel snoop hit", int'(snp_hit), 1);
      look(1'b0, 12'h003, 7, 1'b0, 0, "R11");
   endtask

   initial begin : p_watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_data();
      t_instr();
      t_modified();
      t_collide();
      t_parallel();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule